// File: doc/BRIEF.md
# Bunch-Crossing Timing Frame Packer

This block builds one fixed-layout 120-bit link frame per bunch crossing. On each crossing an input strobe presents a decoded timing broadcast: the trigger accept, the bunch counter reset, the event counter reset, four system bits and eight user bits. It also presents the two raw interleaved timing channel bits, four slow-control bits and a generic user payload. Two clocks later the block emits an assembled frame with a one-cycle valid pulse. The frame has a constant header, the slow-control bits, an 80-bit data area split into ten 8-bit lanes, and a 32-bit error-correction area. The error-correction area is left at zero for a later encoder.

Each lane is configured by two things. A flag selects whether the lane carries timing content or the matching byte of the user payload. A width code selects how much timing content a timing lane carries: the two raw channel bits, a four-bit summary, or an eight-bit summary of the broadcast. Latency does not depend on the content or the configuration. The frame holds its last value between crossings.

Top module: `ttc_frame_packer`

## Requirements
- R1: After reset `frame_vld` is 0 and `frame` is all zeros until the first strobe has passed through.
- R2: A `bc_stb` sampled high at clock edge k gives `frame_vld` high for exactly one cycle after edge k+1. `frame_vld` is never high without such a strobe.
- R3: `frame[119:116]` equals the `HDR_PATTERN` parameter (default 4'b0101) in every emitted frame.
- R4: `frame[115:114]` carries `ic_bits` and `frame[113:112]` carries `ec_bits`, both captured with the strobe.
- R5: `frame[31:0]` is always zero.
- R6: Lane s occupies `frame[39+8s:32+8s]`. When `lane_ttc[s]` is 0, the lane is a copy of `user_data[8s+7:8s]`, whatever its width code.
- R7: A timing lane with width code 0 (2-bit) holds channel A in bit 1 and channel B in bit 0. Lane bits 7..2 are zero.
- R8: A timing lane with width code 1 (4-bit) holds, from bit 3 down to bit 0: trigger accept, bunch counter reset, event counter reset, system bit 3. Lane bits 7..4 are zero.
- R9: A timing lane with width code 2 (8-bit) holds, from bit 7 down to bit 0: trigger accept, bunch counter reset, event counter reset, system bits 3..0, user bit 7. User bits 6..0 do not affect any lane.
- R10: A timing lane with width code 3 (reserved) is all zeros.
- R11: Between strobes the frame keeps its last emitted value. Input changes made without a strobe do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_stb | input | 1 | Crossing strobe: capture all inputs |
| trig_acc | input | 1 | Trigger accept |
| bc_reset | input | 1 | Bunch counter reset |
| ev_reset | input | 1 | Event counter reset |
| sys_bits | input | 4 | System bits of the broadcast |
| usr_bits | input | 8 | User bits of the broadcast |
| chan_a | input | 1 | Raw timing channel A bit |
| chan_b | input | 1 | Raw timing channel B bit |
| ic_bits | input | 2 | Internal slow-control bits |
| ec_bits | input | 2 | External slow-control bits |
| user_data | input | 80 | Generic payload for non-timing lanes |
| lane_ttc | input | 10 | Per-lane timing-content flag |
| lane_wcode | input | 20 | Per-lane width code, 2 bits per lane (lane s at bits 2s+1:2s) |
| frame | output | 120 | Assembled frame |
| frame_vld | output | 1 | One-cycle frame valid pulse |

## Verification
The hardest case to reach from the ports is a single frame that contains every lane kind at once, with each broadcast bit checked in every lane position. An error in the bit order of one width variant shows up only in some lanes and only for some inputs. The bench therefore rotates the lane configuration so that each lane takes every width code and both lane types. Under each configuration it sweeps all 1024 combinations of the mapped broadcast bits and the raw channel bits. The unmapped user bits and the payload change together with the sweep. After each frame the bench changes the inputs without a strobe to confirm that the frame holds.

// File: rtl/ttc_pack_pkg.sv
package ttc_pack_pkg;
  localparam int LANE_W = 8;
  localparam int HDR_W  = 4;
  localparam int SC_W   = 4;
  localparam int FEC_W  = 32;

  localparam logic [1:0] WC_TWO   = 2'd0;
  localparam logic [1:0] WC_FOUR  = 2'd1;
  localparam logic [1:0] WC_EIGHT = 2'd2;

  typedef struct packed {
    logic       trig;
    logic       bcr;
    logic       ecr;
    logic [3:0] sys;
    logic [7:0] usr;
    logic       ch_a;
    logic       ch_b;
  } bcast_t;
endpackage

// File: rtl/ttc_capture.sv
module ttc_capture
  import ttc_pack_pkg::*;
#(
  parameter int DATA_W = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  bcast_t            bc_in,
  input  logic [1:0]        ic_in,
  input  logic [1:0]        ec_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              cap_vld,
  output bcast_t            bc_q,
  output logic [1:0]        ic_q,
  output logic [1:0]        ec_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld <= 1'b0;
      bc_q    <= '0;
      ic_q    <= '0;
      ec_q    <= '0;
      data_q  <= '0;
    end else begin
      cap_vld <= stb;
      if (stb) begin
        bc_q   <= bc_in;
        ic_q   <= ic_in;
        ec_q   <= ec_in;
        data_q <= data_in;
      end
    end
  end

  // R2
  cap_follows_stb_chk: assert property (@(posedge clk) disable iff (rst)
    cap_vld |-> $past(stb));
endmodule

// File: rtl/ttc_lane_fill.sv
module ttc_lane_fill
  import ttc_pack_pkg::*;
(
  input  logic              is_ttc,
  input  logic [1:0]        wcode,
  input  bcast_t            bc,
  input  logic [LANE_W-1:0] user_byte,
  output logic [LANE_W-1:0] lane
);
  always_comb begin
    lane = '0;
    if (!is_ttc) begin
      lane = user_byte;
    end else begin
      unique case (wcode)
        WC_TWO:   lane[1:0] = {bc.ch_a, bc.ch_b};
        WC_FOUR:  lane[3:0] = {bc.trig, bc.bcr, bc.ecr, bc.sys[3]};
        WC_EIGHT: lane      = {bc.trig, bc.bcr, bc.ecr, bc.sys, bc.usr[7]};
        default:  lane      = '0;
      endcase
    end
  end
endmodule

// File: rtl/ttc_frame_reg.sv
module ttc_frame_reg
  import ttc_pack_pkg::*;
#(
  parameter int          DATA_W      = 80,
  parameter logic [3:0]  HDR_PATTERN = 4'b0101,
  localparam int         FRAME_W     = HDR_W + SC_W + DATA_W + FEC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_vld,
  input  logic [1:0]         ic_q,
  input  logic [1:0]         ec_q,
  input  logic [DATA_W-1:0]  lanes,
  output logic [FRAME_W-1:0] frame_q,
  output logic               vld_q
);
  logic [FRAME_W-1:0] next_frame;

  always_comb begin
    next_frame = {HDR_PATTERN, ic_q, ec_q, lanes, {FEC_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= cap_vld;
      if (cap_vld) frame_q <= next_frame;
    end
  end

  // R11
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cap_vld)) |-> $stable(frame_q));
endmodule

// File: rtl/ttc_frame_packer.sv
module ttc_frame_packer
  import ttc_pack_pkg::*;
#(
  parameter int         NUM_LANES   = 10,
  parameter logic [3:0] HDR_PATTERN = 4'b0101,
  localparam int        DATA_W      = NUM_LANES * LANE_W,
  localparam int        FRAME_W     = HDR_W + SC_W + DATA_W + FEC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bc_stb,
  input  logic                   trig_acc,
  input  logic                   bc_reset,
  input  logic                   ev_reset,
  input  logic [3:0]             sys_bits,
  input  logic [7:0]             usr_bits,
  input  logic                   chan_a,
  input  logic                   chan_b,
  input  logic [1:0]             ic_bits,
  input  logic [1:0]             ec_bits,
  input  logic [DATA_W-1:0]      user_data,
  input  logic [NUM_LANES-1:0]   lane_ttc,
  input  logic [2*NUM_LANES-1:0] lane_wcode,
  output logic [FRAME_W-1:0]     frame,
  output logic                   frame_vld
);
  bcast_t             bc_in, bc_q;
  logic               cap_vld;
  logic [1:0]         ic_q, ec_q;
  logic [DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]  lanes;

  always_comb begin
    bc_in.trig = trig_acc;
    bc_in.bcr  = bc_reset;
    bc_in.ecr  = ev_reset;
    bc_in.sys  = sys_bits;
    bc_in.usr  = usr_bits;
    bc_in.ch_a = chan_a;
    bc_in.ch_b = chan_b;
  end

  ttc_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst(rst), .stb(bc_stb), .bc_in(bc_in),
    .ic_in(ic_bits), .ec_in(ec_bits), .data_in(user_data),
    .cap_vld(cap_vld), .bc_q(bc_q), .ic_q(ic_q), .ec_q(ec_q), .data_q(data_q)
  );

  for (genvar s = 0; s < NUM_LANES; s++) begin : g_lane
    ttc_lane_fill u_fill (
      .is_ttc(lane_ttc[s]),
      .wcode(lane_wcode[2*s +: 2]),
      .bc(bc_q),
      .user_byte(data_q[LANE_W*s +: LANE_W]),
      .lane(lanes[LANE_W*s +: LANE_W])
    );
  end

  ttc_frame_reg #(.DATA_W(DATA_W), .HDR_PATTERN(HDR_PATTERN)) u_frame (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .ic_q(ic_q), .ec_q(ec_q),
    .lanes(lanes), .frame_q(frame), .vld_q(frame_vld)
  );

  // R2
  vld_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> $past(bc_stb, 2));
  // R2
  stb_gives_vld_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bc_stb, 2) && !$past(rst) && !$past(rst, 2)) |-> frame_vld);
  // R5
  fec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frame[FEC_W-1:0] == '0);
  // R3
  hdr_const_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> frame[FRAME_W-1 -: HDR_W] == HDR_PATTERN);
endmodule

// File: tb/test_ttc_frame_packer.sv
module test_ttc_frame_packer;
  localparam int NL = 10;
  localparam logic [3:0] HDR = 4'b0101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bc_stb = 1'b0, trig_acc = 1'b0, bc_reset = 1'b0, ev_reset = 1'b0;
  logic [3:0] sys_bits = '0;
  logic [7:0] usr_bits = '0;
  logic chan_a = 1'b0, chan_b = 1'b0;
  logic [1:0] ic_bits = '0, ec_bits = '0;
  logic [79:0] user_data = '0;
  logic [NL-1:0] lane_ttc = '0;
  logic [2*NL-1:0] lane_wcode = '0;
  logic [119:0] frame;
  logic frame_vld;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ttc_frame_packer #(.NUM_LANES(NL), .HDR_PATTERN(HDR)) i_ttc_frame_packer (
    .clk(clk), .rst(rst), .bc_stb(bc_stb), .trig_acc(trig_acc),
    .bc_reset(bc_reset), .ev_reset(ev_reset), .sys_bits(sys_bits),
    .usr_bits(usr_bits), .chan_a(chan_a), .chan_b(chan_b),
    .ic_bits(ic_bits), .ec_bits(ec_bits), .user_data(user_data),
    .lane_ttc(lane_ttc), .lane_wcode(lane_wcode),
    .frame(frame), .frame_vld(frame_vld)
  );

  task automatic chk(input string req, input logic [119:0] act, input logic [119:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lane(input int s);
    logic [7:0] v;
    v = 8'h00;
    if (!lane_ttc[s]) v = user_data[8*s +: 8];
    else case (lane_wcode[2*s +: 2])
      2'd0: v = {6'b0, chan_a, chan_b};
      2'd1: v = {4'b0, trig_acc, bc_reset, ev_reset, sys_bits[3]};
      2'd2: v = {trig_acc, bc_reset, ev_reset, sys_bits, usr_bits[7]};
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic check_lanes();
    for (int s = 0; s < NL; s++) begin
      logic [7:0] e;
      e = exp_lane(s);
      if (!lane_ttc[s]) chk("R6", frame[32+8*s +: 8], e);
      else case (lane_wcode[2*s +: 2])
        2'd0: chk("R7", frame[32+8*s +: 8], e);
        2'd1: chk("R8", frame[32+8*s +: 8], e);
        2'd2: chk("R9", frame[32+8*s +: 8], e);
        default: chk("R10", frame[32+8*s +: 8], e);
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [119:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {119'b0, frame_vld}, 120'b0);
    chk("R1", frame, 120'b0);
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int s = 0; s < NL; s++) begin
        lane_wcode[2*s +: 2] = 2'((s + cfg) % 4);
        lane_ttc[s] = ((s + cfg) % 5) != 4;
      end
      for (int p = 0; p < 1024; p++) begin
        {trig_acc, bc_reset, ev_reset, sys_bits, usr_bits[7], chan_a, chan_b} = 10'(p);
        usr_bits[6:0] = 7'(p * 37 + cfg);
        {ic_bits, ec_bits} = 4'(p + cfg);
        for (int s = 0; s < NL; s++) user_data[8*s +: 8] = 8'(p * 13 + s * 29 + cfg);
        bc_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        bc_stb = 1'b0;
        chk("R2", {119'b0, frame_vld}, 120'b0);
        @(posedge clk); @(negedge clk);
        chk("R2", {119'b0, frame_vld}, 120'd1);
        chk("R3", {116'b0, frame[119:116]}, {116'b0, HDR});
        chk("R4", {116'b0, frame[115:112]}, {116'b0, ic_bits, ec_bits});
        chk("R5", {88'b0, frame[31:0]}, 120'b0);
        check_lanes();
        if (p % 64 == 0) begin
          held = frame;
          {trig_acc, bc_reset, ev_reset, sys_bits, chan_a, chan_b} = ~{trig_acc, bc_reset, ev_reset, sys_bits, chan_a, chan_b};
          user_data = ~user_data;
          ic_bits = ~ic_bits;
          @(posedge clk); @(negedge clk);
          chk("R2", {119'b0, frame_vld}, 120'b0);
          @(posedge clk); @(negedge clk);
          chk("R11", frame, held);
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule